// File: doc/BRIEF.md
# Serial Conversion Control Sequencer

This block is the digital front end of a resistive touch-screen converter. It runs only from the externally supplied serial clock `dclk`, qualified by the active-low select `cs_n`. While select is low, it watches the serial input for a start bit and collects a command byte. That byte carries the input channel, the resolution, the reference style and the power-down setting. The block then paces a short acquisition window and a successive-approximation conversion, bit by bit, against a one-bit comparator result. The result is shifted back out, most significant bit first, on the same clock.

The analog parts lie outside the block. These are the track/hold circuit, the capacitor DAC and the comparator. The block drives them through a track strobe and a trial code `sar_trial`, and reads back the comparator through `cmp_in` (1 means the held input is at or above the trial code). The host may send the next command while the previous result is still leaving the block. A new start bit is accepted every 15th clock in 12-bit mode and every 11th clock in 8-bit mode.

Edges below are counted from the rising `dclk` edge that samples the start bit, which is edge 0.

Top module: `tsc_conv_seq`

## Requirements
- R1: `dout_oe` and `busy_oe` are 1 exactly while `cs_n` is 0, and 0 while `cs_n` is 1.
- R2: While hunting, a 0 on `din` is ignored and the first 1 is the start bit. The next seven rising edges (1 to 7) give the word bits 6 down to 0. On `chan_sel` appear word[6:4], on `res_8b` word[3], on `ref_single` word[2], and on `pwr_mode` word[1:0].
- R3: `track` rises on the falling edge after rising edge 4 and falls on the falling edge after rising edge 7, so it is high for exactly three clocks.
- R4: `busy` is 1 from the falling edge after rising edge 7 to the next falling edge, which is one clock.
- R5: In 12-bit mode (word[3]=0), the trial code holds the decided bits plus the current trial bit. At rising edge 8+j the value of `cmp_in` becomes result bit 11-j. On the falling edge after that, `dout` shows that bit, so the result leaves MSB first as a straight binary code.
- R6: After the LSB has been shown, `dout` is 0 until the next result bit.
- R7: In 8-bit mode (word[3]=1), there are only 8 decisions, on the top 8 trial-code bits. `dout` shows them on the falling edges after rising edges 8 to 15, then 0.
- R8: Hunting for the next start bit resumes at rising edge 15 in 12-bit mode and at edge 11 in 8-bit mode. A 1 on `din` at earlier edges after the word is ignored. The next word's shift-in overlaps the previous shift-out.
- R9: `chan_sel`, `res_8b`, `ref_single` and `pwr_mode` change only at rising edge 7 of a complete word, so the power-down bits take effect at conversion start.
- R10: `cs_n` high aborts any frame at once. `track`, `busy` and `dout` go to 0, the latched fields keep their values, and the next frame is parsed from a fresh hunt.
- R11: After `rst_n` is low, the fields are 0 and `track`, `busy` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial and conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high aborts the frame |
| din | input | 1 | Serial command input, sampled on rising edges |
| cmp_in | input | 1 | Comparator result: held input is at or above the trial code |
| dout | output | 1 | Serial result, updated on falling edges |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | One-clock conversion-start flag |
| busy_oe | output | 1 | Output enable for `busy` |
| track | output | 1 | Track (1) / hold (0) strobe for the sampler |
| sar_trial | output | 12 | Trial code for the DAC |
| chan_sel | output | 3 | Latched channel select |
| res_8b | output | 1 | Latched resolution: 1 means 8 bits |
| ref_single | output | 1 | Latched reference style: 1 means single-ended |
| pwr_mode | output | 2 | Latched power-down setting |

## Verification
The case hardest to reach is the overlapped frame. It needs a new start bit at exactly the 15th (or 11th) edge while the previous result is still shifting out, and a stray 1 placed one edge earlier that must be ignored. The stimulus builds whole bit streams edge by edge. It switches the comparator's modelled input voltage between the two conversions, so each result can be told apart from the other. A second hard case is an abort in the middle of a word: select is raised during acquisition, and the test then shows that a following clean frame parses correctly.

// File: rtl/tsc_seq_pkg.sv
package tsc_seq_pkg;
   localparam int CMD_BITS = 8;

   typedef struct packed {
      logic [2:0] chan;
      logic       res8;
      logic       single;
      logic [1:0] pd;
   } ctrl_t;
endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx
   import tsc_seq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic  dclk,
   input  logic  rst_n,
   input  logic  seq_rst_n,
   input  logic  din,
   output logic  launch,
   output logic  acq_win,
   output ctrl_t word_next,
   output ctrl_t fields
);
   localparam int CNT_W  = $clog2(CMD_BITS);
   localparam int SH_W   = CMD_BITS - 2;
   localparam int GAP_HI = RES_W + 3 - CMD_BITS;
   localparam int GAP_LO = LOW_W + 3 - CMD_BITS;
   localparam int HW     = $clog2(GAP_HI + 1);

   initial begin
      assert (LOW_W < RES_W) else $error("LOW_W must be below RES_W");
      assert (GAP_LO >= 1) else $error("LOW_W too small for frame overlap");
   end

   logic [CNT_W-1:0] cnt;
   logic [HW-1:0]    holdoff;
   logic [SH_W-1:0]  shreg;
   logic             hunt;

   assign hunt      = (cnt == '0) && (holdoff == '0);
   assign launch    = (cnt == CNT_W'(CMD_BITS - 1));
   assign acq_win   = (cnt >= CNT_W'(CMD_BITS - 3));
   assign word_next = ctrl_t'({shreg, din});

   always_ff @(posedge dclk or negedge seq_rst_n) begin
      if (!seq_rst_n) begin
         cnt     <= '0;
         holdoff <= '0;
         shreg   <= '0;
      end else if (launch) begin
         cnt     <= '0;
         holdoff <= word_next.res8 ? HW'(GAP_LO) : HW'(GAP_HI);
      end else if (cnt != '0) begin
         cnt   <= cnt + 1'b1;
         shreg <= {shreg[SH_W-2:0], din};
      end else if (holdoff != '0) begin
         holdoff <= holdoff - 1'b1;
      end else if (din) begin
         cnt <= CNT_W'(1);
      end
   end

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n)      fields <= '0;
      else if (launch) fields <= word_next;
   end

   // R2: zeros during the hunt leave the receiver hunting
   assert_hunt_ignore_R2: assert property (@(posedge dclk) disable iff (!seq_rst_n)
      (hunt && !din) |=> hunt);
   // R8: no hunting directly after a word completes
   assert_no_early_start_R8: assert property (@(posedge dclk) disable iff (!seq_rst_n)
      launch |=> !hunt);
   // R9: fields move only on a completed word
   assert_fields_hold_R9: assert property (@(posedge dclk) disable iff (!rst_n)
      !launch |=> $stable(fields));
endmodule

// File: rtl/tsc_sar_core.sv
module tsc_sar_core #(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic             dclk,
   input  logic             seq_rst_n,
   input  logic             launch,
   input  logic             launch_res8,
   input  logic             acq_win,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial,
   output logic             track,
   output logic             busy,
   output logic             dout
);
   localparam int SW = $clog2(RES_W + 2);
   localparam int IW = $clog2(RES_W);
   localparam logic [SW-1:0] IDLE = SW'(RES_W + 1);

   initial begin
      assert (RES_W <= 16) else $error("RES_W above 16 unsupported");
      assert (LOW_W > 0 && LOW_W < RES_W) else $error("LOW_W out of range");
   end

   logic [SW-1:0]    nstep;
   logic [SW-1:0]    steps;
   logic             res8_q;
   logic             dec_en;
   logic [RES_W-1:0] sar;
   logic [IW-1:0]    sel_idx;
   logic             out_bit;

   assign steps  = res8_q ? SW'(LOW_W) : SW'(RES_W);
   assign dec_en = (nstep < steps);

   always_ff @(posedge dclk or negedge seq_rst_n) begin
      if (!seq_rst_n) begin
         nstep  <= IDLE;
         res8_q <= 1'b0;
      end else if (launch) begin
         nstep  <= '0;
         res8_q <= launch_res8;
      end else if (dec_en) begin
         nstep <= nstep + 1'b1;
      end else begin
         nstep <= IDLE;
      end
   end

   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      logic q;
      logic cur;
      assign cur = dec_en && (nstep == SW'(RES_W - 1 - b));
      always_ff @(posedge dclk or negedge seq_rst_n) begin
         if (!seq_rst_n)  q <= 1'b0;
         else if (launch) q <= 1'b0;
         else if (cur)    q <= cmp_in;
      end
      assign sar[b]   = q;
      assign trial[b] = q | cur;
   end

   assign sel_idx = IW'(RES_W - int'(nstep));

   always_comb begin
      out_bit = 1'b0;
      if (nstep != '0 && nstep <= steps) out_bit = sar[sel_idx];
   end

   always_ff @(negedge dclk or negedge seq_rst_n) begin
      if (!seq_rst_n) begin
         track <= 1'b0;
         busy  <= 1'b0;
         dout  <= 1'b0;
      end else begin
         track <= acq_win;
         busy  <= (nstep == '0);
         dout  <= out_bit;
      end
   end

   // R3: acquisition window is three clocks long
   assert_track_window_R3: assert property (@(negedge dclk) disable iff (!seq_rst_n)
      $rose(track) |=> track ##1 track ##1 !track);
   // R4: busy lasts one clock
   assert_busy_pulse_R4: assert property (@(negedge dclk) disable iff (!seq_rst_n)
      busy |=> !busy);
   // R4: hold and busy begin together
   assert_busy_at_hold_R4: assert property (@(negedge dclk) disable iff (!seq_rst_n)
      $fell(track) |-> busy);
   // R5: step counter stays within the active range or idle
   assert_step_range_R5: assert property (@(posedge dclk) disable iff (!seq_rst_n)
      (nstep <= steps) || (nstep == IDLE));
endmodule

// File: rtl/tsc_conv_seq.sv
module tsc_conv_seq
   import tsc_seq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int LOW_W = 8
) (
   input  logic             dclk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             din,
   input  logic             cmp_in,
   output logic             dout,
   output logic             dout_oe,
   output logic             busy,
   output logic             busy_oe,
   output logic             track,
   output logic [RES_W-1:0] sar_trial,
   output logic [2:0]       chan_sel,
   output logic             res_8b,
   output logic             ref_single,
   output logic [1:0]       pwr_mode
);
   logic  seq_rst_n;
   logic  launch;
   logic  acq_win;
   ctrl_t word_next;
   ctrl_t fields;

   assign seq_rst_n = rst_n & ~cs_n;
   assign dout_oe   = ~cs_n;
   assign busy_oe   = ~cs_n;

   tsc_cmd_rx #(.RES_W(RES_W), .LOW_W(LOW_W)) u_rx (
      .dclk      (dclk),
      .rst_n     (rst_n),
      .seq_rst_n (seq_rst_n),
      .din       (din),
      .launch    (launch),
      .acq_win   (acq_win),
      .word_next (word_next),
      .fields    (fields)
   );

   tsc_sar_core #(.RES_W(RES_W), .LOW_W(LOW_W)) u_core (
      .dclk        (dclk),
      .seq_rst_n   (seq_rst_n),
      .launch      (launch),
      .launch_res8 (word_next.res8),
      .acq_win     (acq_win),
      .cmp_in      (cmp_in),
      .trial       (sar_trial),
      .track       (track),
      .busy        (busy),
      .dout        (dout)
   );

   assign chan_sel   = fields.chan;
   assign res_8b     = fields.res8;
   assign ref_single = fields.single;
   assign pwr_mode   = fields.pd;
endmodule

// File: tb/tsc_conv_seq_tb.sv
module tsc_conv_seq_tb;
   localparam int RW = 12;
   localparam int NV = 6;
   localparam logic [7:0]  V_CMD  [NV] = '{8'h93, 8'hD4, 8'hED, 8'hBA, 8'hC1, 8'h9E};
   localparam logic [11:0] V_VIN  [NV] = '{12'hA5C, 12'h000, 12'hFFF, 12'h3C7, 12'h800, 12'h7FF};
   localparam int          V_LEAD [NV] = '{0, 3, 1, 5, 2, 0};

   logic dclk = 1'b0;
   always #10 dclk = ~dclk;

   logic rst_n, cs_n, din, cmp_in;
   logic dout, dout_oe, busy, busy_oe, track;
   logic [RW-1:0] sar_trial;
   logic [2:0] chan_sel;
   logic res_8b, ref_single;
   logic [1:0] pwr_mode;
   logic [11:0] vin, vin_b;
   int vin_sw;

   assign cmp_in = (sar_trial <= vin);

   tsc_conv_seq u_dut (
      .dclk(dclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp_in(cmp_in),
      .dout(dout), .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe),
      .track(track), .sar_trial(sar_trial), .chan_sel(chan_sel),
      .res_8b(res_8b), .ref_single(ref_single), .pwr_mode(pwr_mode)
   );

   int checks = 0;
   int fails  = 0;

   logic       din_seq  [0:63];
   logic       obs_trk  [0:63];
   logic       obs_busy [0:63];
   logic       obs_dout [0:63];
   logic [6:0] obs_fld  [0:63];

   function automatic logic [6:0] fld_now();
      return {chan_sel, res_8b, ref_single, pwr_mode};
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_seq();
      for (int i = 0; i < 64; i++) din_seq[i] = 1'b0;
   endtask

   task automatic put_cmd(int base, logic [7:0] cmd);
      for (int i = 0; i < 8; i++) din_seq[base + i] = cmd[7 - i];
   endtask

   task automatic run_seq(int n);
      for (int e = 0; e <= n; e++) begin
         @(negedge dclk); #2;
         cs_n = 1'b0;
         if (e > 0) begin
            obs_trk[e-1]  = track;
            obs_busy[e-1] = busy;
            obs_dout[e-1] = dout;
            obs_fld[e-1]  = fld_now();
         end
         if (e == vin_sw) vin = vin_b;
         din = (e < n) ? din_seq[e] : 1'b0;
      end
   endtask

   task automatic end_frame();
      @(negedge dclk); #2;
      cs_n = 1'b1;
      din  = 1'b0;
      #2;
   endtask

   task automatic check_frame(int base, logic [7:0] cmd, logic [11:0] v, logic [6:0] prev);
      int nb;
      logic [11:0] expv;
      nb   = cmd[3] ? 8 : 12;
      expv = cmd[3] ? {4'h0, v[11:4]} : v;
      chk("R3 track low before window", int'(obs_trk[base+3]), 0);
      for (int e = 4; e <= 6; e++) chk("R3 track high in window", int'(obs_trk[base+e]), 1);
      chk("R3 track low at hold", int'(obs_trk[base+7]), 0);
      chk("R4 busy low before hold", int'(obs_busy[base+6]), 0);
      chk("R4 busy high at hold", int'(obs_busy[base+7]), 1);
      chk("R4 busy low after one clock", int'(obs_busy[base+8]), 0);
      for (int j = 0; j < nb; j++)
         chk(cmd[3] ? "R7 8-bit result bit" : "R5 12-bit result bit",
             int'(obs_dout[base+8+j]), int'(expv[nb-1-j]));
      for (int j = 0; j < 3; j++)
         chk("R6 zero after LSB", int'(obs_dout[base+8+nb+j]), 0);
      chk("R9 fields held before last bit", int'(obs_fld[base+6]), int'(prev));
      chk("R2 fields from word", int'(obs_fld[base+7]), int'(cmd[6:0]));
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [6:0] prev;
      rst_n = 1'b0; cs_n = 1'b1; din = 1'b0; vin = '0; vin_b = '0; vin_sw = -1;
      repeat (3) @(negedge dclk);
      #2;
      chk("R11 fields zero", int'(fld_now()), 0);
      chk("R11 busy low", int'(busy), 0);
      chk("R11 track low", int'(track), 0);
      chk("R11 dout low", int'(dout), 0);
      chk("R1 dout_oe off while deselected", int'(dout_oe), 0);
      chk("R1 busy_oe off while deselected", int'(busy_oe), 0);
      rst_n = 1'b1;
      prev  = '0;

      // table of single frames
      for (int v = 0; v < NV; v++) begin
         clear_seq();
         put_cmd(V_LEAD[v], V_CMD[v]);
         vin = V_VIN[v];
         vin_sw = -1;
         run_seq(V_LEAD[v] + 24);
         chk("R1 dout_oe on while selected", int'(dout_oe), 1);
         chk("R1 busy_oe on while selected", int'(busy_oe), 1);
         check_frame(V_LEAD[v], V_CMD[v], V_VIN[v], prev);
         end_frame();
         chk("R1 dout_oe off after deselect", int'(dout_oe), 0);
         prev = V_CMD[v][6:0];
      end

      // R10: abort during acquisition
      clear_seq();
      put_cmd(0, 8'hF5);
      vin = 12'h123;
      run_seq(5);
      chk("R10 track seen before abort", int'(obs_trk[4]), 1);
      end_frame();
      chk("R10 track cleared by abort", int'(track), 0);
      chk("R10 busy cleared by abort", int'(busy), 0);
      chk("R10 dout cleared by abort", int'(dout), 0);
      chk("R10 fields kept on abort", int'(fld_now()), int'(prev));
      clear_seq();
      put_cmd(0, 8'hA4);
      vin = 12'h2B1;
      run_seq(24);
      check_frame(0, 8'hA4, 12'h2B1, prev);
      end_frame();
      prev = 7'h24;

      // R8: overlapped 12-bit frames, stray 1 one edge early
      clear_seq();
      put_cmd(0, 8'h93);
      din_seq[14] = 1'b1;
      put_cmd(15, 8'hA4);
      vin = 12'h5A3; vin_b = 12'h1E6; vin_sw = 21;
      run_seq(15 + 24);
      check_frame(0, 8'h93, 12'h5A3, prev);
      check_frame(15, 8'hA4, 12'h1E6, 7'h13);
      chk("R8 12-bit overlap word taken", int'(obs_fld[38]), 16'h24);
      end_frame();
      prev = 7'h24;

      // R8: overlapped 8-bit frames, stray 1 one edge early
      clear_seq();
      put_cmd(0, 8'hB8);
      din_seq[10] = 1'b1;
      put_cmd(11, 8'hC9);
      vin = 12'hC3A; vin_b = 12'h4F0; vin_sw = 17;
      run_seq(11 + 24);
      check_frame(0, 8'hB8, 12'hC3A, prev);
      check_frame(11, 8'hC9, 12'h4F0, 7'h38);
      chk("R8 8-bit overlap word taken", int'(obs_fld[34]), 16'h49);
      end_frame();
      vin_sw = -1;

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule